// File: doc/BRIEF.md
# Averaging Counter Phase Detector with PI Loop and Holdover

This block compares a recovered reference carrier against a local oscillator and produces a control code for the oscillator's tuning DAC. Both inputs come into the block synchronous to a fast, free-running counting clock that is unrelated to either of them. The reference arrives as a level signal. The local oscillator arrives as a one-cycle tick. A phase counter restarts on every local tick. At each qualified rising edge of the reference, the counter value is taken as one phase sample.

A rising edge only counts as a tick when the gap since the previous rising edge lies inside a configured window. Sampling begins only after a run of such clean ticks, so edges disturbed by neighbouring symbols are ignored. A fixed power-of-two number of samples is summed and then dumped. The mean minus a setpoint, clamped to a symmetric limit, is the phase error.

Each error updates a proportional-integral filter built from shifts, whose output is clamped to the DAC range. A slow running average of that output is kept. When the reference goes silent for longer than a timeout, the block enters holdover. In holdover the DAC code is pinned to the running average, and the integrator is preloaded with the same value so that reacquisition starts from it.

Top module: `ph_averaging_pd`

## Requirements
- R1: During and right after reset: pd_valid = 0, pd_err = 0, dac_code = 2^(DAC_W-1), holdover = 1.
- R2: A rising edge of ref_in is a clean tick when the gap since the previous rising edge (gap = 1 + count of clk cycles in between) lies in [PER_LO, PER_HI], both bounds inclusive. A rising edge with any other gap resets the clean-tick run to zero.
- R3: A phase sample is taken only at a clean tick preceded by at least CLEAN_TICKS consecutive clean ticks. Its value is the count of clk cycles since the last loc_tick (0 in the cycle after loc_tick), saturating at 2^PH_W-1.
- R4: After 2^LOG_N samples, pd_valid pulses high for exactly one cycle, the cycle after the final sample's edge. pd_err = floor(sum / 2^LOG_N) - SETPOINT, clamped to [-ERR_LIM, +ERR_LIM]. pd_err holds its value until the next result.
- R5: On each result outside holdover, the integrator becomes clamp(integ + err*2^KI_SH) and dac_code becomes clamp(new integ + err*2^KP_SH), both clamped to [0, 2^DAC_W-1]. dac_code shows the new value one cycle after pd_valid.
- R6: Outside holdover, dac_code changes only in the cycle after a pd_valid pulse.
- R7: holdover is 1 once TIMEOUT clk cycles have passed since the last rising edge of ref_in. It returns to 0 in the cycle after the next rising edge.
- R8: A running average A (reset value 2^(DAC_W-1) * 2^AVG_SH) is updated on each result as A + dac_new - floor(A / 2^AVG_SH). While holdover = 1, A is frozen. One cycle later, dac_code and the integrator take the value floor(A / 2^AVG_SH) and hold it.
- R9: A partial sum is discarded, and the sample count restarts, on a rising edge that is not clean and whenever holdover is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference carrier level, synchronous to clk |
| loc_tick | input | 1 | One-cycle pulse per local oscillator period |
| pd_err | output | ERR_W | Signed, clamped, averaged phase error |
| pd_valid | output | 1 | One-cycle strobe for a new pd_err |
| dac_code | output | DAC_W | Oscillator tuning code |
| holdover | output | 1 | Reference lost; DAC pinned to the running average |

## Verification
The bench builds the block with LOG_N = 2, so each result needs only four samples and arrives about every forty cycles. A window of 8 to 12 cycles lets both window bounds and out-of-window gaps be driven directly. SETPOINT = 8 with ERR_LIM = 5 lets both error clamps be reached: a silent local tick drives the error positive, and a local tick just ahead of the reference drives it negative. DAC_W = 8 with shifts of 1 and 2 drives the DAC to both rails within a few hundred cycles. TIMEOUT = 30 and AVG_SH = 2 make holdover entry, the frozen average and reacquisition quick to reach.

// File: rtl/ph_det_pkg.sv
package ph_det_pkg;
    function automatic int sat_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction
endpackage

// File: rtl/ref_qualifier.sv
module ref_qualifier #(
    parameter int PER_LO      = 80,
    parameter int PER_HI      = 100,
    parameter int TIMEOUT     = 400,
    parameter int CLEAN_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic take_o,
    output logic drop_o,
    output logic lost_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam int RUN_W = $clog2(CLEAN_TICKS + 1);

    typedef struct packed {
        logic             ref_lvl;
        logic [CNT_W-1:0] gap;
        logic [RUN_W-1:0] run;
    } qual_t;

    qual_t q, d;
    logic  rise, clean;
    int    gap_len;

    always_comb begin
        d       = q;
        rise    = ref_in & ~q.ref_lvl;
        gap_len = int'(q.gap) + 1;
        clean   = rise && (gap_len >= PER_LO) && (gap_len <= PER_HI);
        lost_o  = (q.gap == CNT_W'(TIMEOUT));
        take_o  = clean && (q.run == RUN_W'(CLEAN_TICKS));
        drop_o  = (rise && !clean) || lost_o;

        d.ref_lvl = ref_in;
        if (rise)
            d.gap = '0;
        else if (q.gap != CNT_W'(TIMEOUT))
            d.gap = q.gap + CNT_W'(1);
        if (rise) begin
            if (!clean)
                d.run = '0;
            else if (q.run != RUN_W'(CLEAN_TICKS))
                d.run = q.run + RUN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ref_lvl <= 1'b0;
            q.gap     <= CNT_W'(TIMEOUT);
            q.run     <= '0;
        end else begin
            q <= d;
        end
    end

    // R7
    holdover_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> !take_o);
endmodule

// File: rtl/phase_avg.sv
module phase_avg
    import ph_det_pkg::*;
#(
    parameter int PH_W     = 8,
    parameter int LOG_N    = 11,
    parameter int SETPOINT = 45,
    parameter int ERR_LIM  = 100,
    parameter int ERR_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    loc_tick,
    input  logic                    take_i,
    input  logic                    drop_i,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    valid_o
);
    localparam int ACC_W = PH_W + LOG_N;
    localparam int N_SMP = 1 << LOG_N;

    typedef struct packed {
        logic [PH_W-1:0]         ph;
        logic [ACC_W-1:0]        acc;
        logic [LOG_N-1:0]        n;
        logic signed [ERR_W-1:0] err;
        logic                    valid;
    } avg_t;

    avg_t             q, d;
    logic [ACC_W-1:0] sum;
    int               mean;
    int               e_sat;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        sum     = q.acc + ACC_W'(q.ph);
        mean    = int'(sum >> LOG_N);
        e_sat   = sat_int(mean - SETPOINT, -ERR_LIM, ERR_LIM);

        if (loc_tick)
            d.ph = '0;
        else if (q.ph != {PH_W{1'b1}})
            d.ph = q.ph + PH_W'(1);

        if (drop_i) begin
            d.acc = '0;
            d.n   = '0;
        end else if (take_i) begin
            if (q.n == LOG_N'(N_SMP - 1)) begin
                d.err   = ERR_W'(e_sat);
                d.valid = 1'b1;
                d.acc   = '0;
                d.n     = '0;
            end else begin
                d.acc = sum;
                d.n   = q.n + LOG_N'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign err_o   = q.err;
    assign valid_o = q.valid;

    // R4
    err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(err_o) <= ERR_LIM) && (int'(err_o) >= -ERR_LIM));
    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/pi_hold.sv
module pi_hold
    import ph_det_pkg::*;
#(
    parameter int ERR_W  = 8,
    parameter int DAC_W  = 16,
    parameter int KP_SH  = 4,
    parameter int KI_SH  = 0,
    parameter int AVG_SH = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic                    valid_i,
    input  logic                    lost_i,
    output logic [DAC_W-1:0]        dac_o
);
    localparam int MAXC  = (1 << DAC_W) - 1;
    localparam int MID   = 1 << (DAC_W - 1);
    localparam int AVG_W = DAC_W + AVG_SH;

    typedef struct packed {
        logic [DAC_W-1:0] integ;
        logic [DAC_W-1:0] dac;
        logic [AVG_W-1:0] avg;
    } pi_t;

    pi_t              q, d;
    logic [DAC_W-1:0] hold;
    int               e, i_new, c_new, a_new;

    always_comb begin
        d     = q;
        hold  = DAC_W'(q.avg >> AVG_SH);
        e     = int'(err_i);
        i_new = sat_int(int'(q.integ) + (e <<< KI_SH), 0, MAXC);
        c_new = sat_int(i_new + (e <<< KP_SH), 0, MAXC);
        a_new = int'(q.avg) + c_new - int'(q.avg >> AVG_SH);
        if (lost_i) begin
            d.integ = hold;
            d.dac   = hold;
        end else if (valid_i) begin
            d.integ = DAC_W'(i_new);
            d.dac   = DAC_W'(c_new);
            d.avg   = AVG_W'(a_new);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.integ <= DAC_W'(MID);
            q.dac   <= DAC_W'(MID);
            q.avg   <= AVG_W'(MID) << AVG_SH;
        end else begin
            q <= d;
        end
    end

    assign dac_o = q.dac;

    // R6
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i && !lost_i) |=> $stable(dac_o));
    // R8
    holdover_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_i && $past(lost_i)) |=> $stable(dac_o));
endmodule

// File: rtl/ph_averaging_pd.sv
module ph_averaging_pd #(
    parameter int PER_LO      = 80,
    parameter int PER_HI      = 100,
    parameter int TIMEOUT     = 400,
    parameter int CLEAN_TICKS = 3,
    parameter int PH_W        = 8,
    parameter int LOG_N       = 11,
    parameter int SETPOINT    = 45,
    parameter int ERR_LIM     = 100,
    parameter int ERR_W       = 8,
    parameter int DAC_W       = 16,
    parameter int KP_SH       = 4,
    parameter int KI_SH       = 0,
    parameter int AVG_SH      = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_in,
    input  logic                    loc_tick,
    output logic signed [ERR_W-1:0] pd_err,
    output logic                    pd_valid,
    output logic [DAC_W-1:0]        dac_code,
    output logic                    holdover
);
    logic take, drop, lost;

    ref_qualifier #(
        .PER_LO(PER_LO), .PER_HI(PER_HI), .TIMEOUT(TIMEOUT), .CLEAN_TICKS(CLEAN_TICKS)
    ) u_qual (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
        .take_o(take), .drop_o(drop), .lost_o(lost)
    );

    phase_avg #(
        .PH_W(PH_W), .LOG_N(LOG_N), .SETPOINT(SETPOINT), .ERR_LIM(ERR_LIM), .ERR_W(ERR_W)
    ) u_avg (
        .clk(clk), .rst_n(rst_n), .loc_tick(loc_tick), .take_i(take), .drop_i(drop),
        .err_o(pd_err), .valid_o(pd_valid)
    );

    pi_hold #(
        .ERR_W(ERR_W), .DAC_W(DAC_W), .KP_SH(KP_SH), .KI_SH(KI_SH), .AVG_SH(AVG_SH)
    ) u_pi (
        .clk(clk), .rst_n(rst_n), .err_i(pd_err), .valid_i(pd_valid), .lost_i(lost),
        .dac_o(dac_code)
    );

    assign holdover = lost;
endmodule

// File: tb/ph_averaging_pd_test.sv
module ph_averaging_pd_test;
    localparam int LO = 8, HI = 12, TMO = 30, CT = 3, PHW = 6, LGN = 2;
    localparam int SP = 8, LIM = 5, EW = 6, DW = 8, KP = 2, KI = 1, ASH = 2;
    localparam int DMAX = (1 << DW) - 1;
    localparam int PMAX = (1 << PHW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0, loc_tick = 1'b0;
    logic signed [EW-1:0] pd_err;
    logic pd_valid, holdover;
    logic [DW-1:0] dac_code;

    ph_averaging_pd #(
        .PER_LO(LO), .PER_HI(HI), .TIMEOUT(TMO), .CLEAN_TICKS(CT), .PH_W(PHW),
        .LOG_N(LGN), .SETPOINT(SP), .ERR_LIM(LIM), .ERR_W(EW), .DAC_W(DW),
        .KP_SH(KP), .KI_SH(KI), .AVG_SH(ASH)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .loc_tick(loc_tick),
        .pd_err(pd_err), .pd_valid(pd_valid), .dac_code(dac_code), .holdover(holdover)
    );

    always #10 clk = ~clk;

    int vectors = 0, fails = 0, valid_seen = 0;
    int loc_per = 0, loc_ph = 0;
    bit done = 0;

    // behavioural reference state
    int m_since, m_run, m_ph, m_acc, m_n, m_err, m_valid, m_integ, m_dac, m_avg;
    bit m_pref;

    function automatic int clampi(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_since = TMO; m_run = 0; m_ph = 0; m_acc = 0; m_n = 0; m_err = 0;
            m_valid = 0; m_integ = 1 << (DW-1); m_dac = m_integ; m_avg = m_integ << ASH;
            m_pref = 0;
        end else begin
            bit lost, rise, clean;
            int gap, c, nv;
            lost  = (m_since >= TMO);
            rise  = ref_in && !m_pref;
            gap   = m_since + 1;
            clean = rise && gap >= LO && gap <= HI;
            // loop filter (R5, R8)
            if (lost) begin
                m_integ = m_avg / (1 << ASH);
                m_dac   = m_integ;
            end else if (m_valid != 0) begin
                m_integ = clampi(m_integ + m_err * (1 << KI), 0, DMAX);
                c = clampi(m_integ + m_err * (1 << KP), 0, DMAX);
                m_dac = c;
                m_avg = m_avg + c - m_avg / (1 << ASH);
            end
            // detector (R2, R3, R4, R9)
            nv = 0;
            if ((rise && !clean) || lost) begin
                m_acc = 0; m_n = 0;
            end else if (clean && m_run >= CT) begin
                m_acc += m_ph; m_n++;
                if (m_n == (1 << LGN)) begin
                    m_err = clampi(m_acc / (1 << LGN) - SP, -LIM, LIM);
                    nv = 1; m_acc = 0; m_n = 0;
                end
            end
            m_valid = nv;
            if (rise) m_run = clean ? ((m_run < CT) ? m_run + 1 : CT) : 0;
            m_since = rise ? 0 : ((m_since < TMO) ? m_since + 1 : TMO);
            m_ph = loc_tick ? 0 : ((m_ph < PMAX) ? m_ph + 1 : PMAX);
            m_pref = ref_in;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit r);
        @(negedge clk);
        check(pd_valid == m_valid[0], "R3 pd_valid", int'(pd_valid), m_valid);
        check(int'(pd_err) == m_err, "R4 pd_err", int'(pd_err), m_err);
        check(int'(dac_code) == m_dac, "R5 R6 dac_code", int'(dac_code), m_dac);
        check(holdover == (m_since >= TMO), "R7 holdover", int'(holdover), int'(m_since >= TMO));
        if (pd_valid) valid_seen++;
        ref_in = r;
        loc_tick = (loc_per > 0 && loc_ph == 0);
        if (loc_per > 0) loc_ph = (loc_ph + 1) % loc_per;
    endtask

    task automatic ref_cycle(input int hi, input int lo);
        for (int i = 0; i < hi; i++) step(1'b1);
        for (int i = 0; i < lo; i++) step(1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        check(pd_valid == 1'b0, "R1 pd_valid", int'(pd_valid), 0);
        check(pd_err == '0, "R1 pd_err", int'(pd_err), 0);
        check(int'(dac_code) == (1 << (DW-1)), "R1 dac_code", int'(dac_code), 1 << (DW-1));
        check(holdover == 1'b1, "R1 holdover", int'(holdover), 1);
        rst_n = 1'b1;

        // steady lock, local tick every 10 cycles
        loc_per = 10; loc_ph = 4;
        for (int k = 0; k < 20; k++) ref_cycle(5, 5);
        check(holdover == 1'b0, "R7 released", int'(holdover), 0);

        // silent local tick: phase saturates, positive clamp, DAC to top rail (R4, R5)
        loc_per = 0;
        for (int k = 0; k < 70; k++) ref_cycle(5, 5);
        check(int'(dac_code) == DMAX, "R5 top rail", int'(dac_code), DMAX);

        // local tick just ahead of reference: negative clamp, DAC to bottom rail
        loc_per = 10; loc_ph = 1;
        for (int k = 0; k < 130; k++) ref_cycle(5, 5);
        check(int'(dac_code) == 0, "R5 bottom rail", int'(dac_code), 0);

        // glitch, then too few clean ticks for a result (R2, R3, R9)
        ref_cycle(2, 2);
        valid_seen = 0;
        for (int k = 0; k < 6; k++) ref_cycle(5, 5);
        check(valid_seen == 0, "R3 run restart", valid_seen, 0);

        // gaps at both window bounds still count as clean (R2)
        loc_per = 7; loc_ph = 0;
        valid_seen = 0;
        for (int k = 0; k < 12; k++) begin ref_cycle(4, 4); ref_cycle(6, 6); end
        check(valid_seen > 0, "R2 bounds clean", valid_seen, 1);
        // over-long gap breaks the run (R2)
        ref_cycle(7, 6);
        for (int k = 0; k < 10; k++) ref_cycle(5, 6);

        // partial sum then loss of reference (R9, R7, R8)
        for (int k = 0; k < 5; k++) ref_cycle(5, 5);
        for (int k = 0; k < TMO + 5; k++) step(1'b0);
        check(holdover == 1'b1, "R7 timeout", int'(holdover), 1);
        begin
            int held = int'(dac_code);
            for (int k = 0; k < 20; k++) step(1'b0);
            check(int'(dac_code) == held, "R8 frozen", int'(dac_code), held);
            check(int'(dac_code) == m_avg / (1 << ASH), "R8 average", int'(dac_code), m_avg / (1 << ASH));
        end

        // reacquire with an irregular period pattern
        loc_per = 9; loc_ph = 3;
        for (int k = 0; k < 30; k++) begin ref_cycle(5, 4); ref_cycle(5, 6); end
        check(holdover == 1'b0, "R7 reacquire", int'(holdover), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule